// File: doc/BRIEF.md
# Set/clear interrupt mask register bank

This block holds a small bank of interrupt enable, mask and priority registers behind a simple request/acknowledge bus. Each register is reached through one or two addresses. A register with two addresses merges written data into the stored value: the set address ORs bits in and the clear address removes them. A register with a single address is overwritten directly. The address compare ignores the top three address bits, so every register shows up in several aliased windows of the address space.

After a write, the bank compares the old and new register value field by field. A field is one bit for mask-style registers and `PRIO_FW` bits for priority registers. Every field that changed becomes one enable or disable strobe, tagged with the index of the interrupt source that field governs. A downstream source aggregator consumes these strobes over a valid/ready channel. The bus write is acknowledged only after the last strobe has been taken, so software sees the enable state settle before its access completes.

Top module: `intc_bank`

## Requirements
- R1: Only address bits 28:0 take part in register matching. Addresses differing only in bits 31:29 reach the same register, and an address differing in any of bits 28:0 does not.
- R2: For a register with both a set and a clear address, a write to the set address stores old value OR write data.
- R3: For a register with both addresses, a write to the clear address stores old value AND NOT write data.
- R4: A non-priority register with only a set address is overwritten directly. A 1 bit means the source is enabled.
- R5: A non-priority register with only a clear address is overwritten directly. A 1 bit means the source is masked, so a bit rising from 0 to 1 yields a disable strobe and a bit falling yields an enable strobe.
- R6: In a mask-style register, field k is bit DATA_W-1-k and drives source SRC_BASE+k.
- R7: A priority register has DATA_W/PRIO_FW fields of PRIO_FW bits. Field k occupies the k-th slice counted from the most significant end and drives source SRC_BASE+k. A changed field yields enable when its new value is non-zero and disable when it is zero. Dual-address priority registers merge as in R2/R3, and single-address ones are overwritten.
- R8: A write strobes only changed fields, one per accepted handshake, with the lowest k (most significant field) first. ev_valid, ev_src and ev_enable hold steady while ev_ready is low.
- R9: bus_ready is a one-cycle pulse. It never coincides with ev_valid and arrives only after every strobe of the write has been accepted.
- R10: A read of a matching address returns the stored value on bus_rdata in the bus_ready cycle and produces no strobe.
- R11: An access to an address that matches no register reads as zero, changes no register and produces no strobe.
- R12: After reset all registers are zero, and bus_ready and ev_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | DATA_W | Read data, valid with bus_ready |
| ev_valid | output | 1 | Enable/disable strobe pending |
| ev_ready | input | 1 | Aggregator accepts the strobe |
| ev_enable | output | 1 | 1 = enable the source, 0 = disable it |
| ev_src | output | SRC_W | Source index of the strobe |

## Verification
Strobe emission and bus completion compete for the same cycle. The last strobe handshake of a write and the bus acknowledge could both fire in that cycle if the sequencing is off. The bench throttles ev_ready with an irregular pattern while sweeping every 8-bit data value through every register kind. This places the final handshake at many different offsets from the acknowledge. At acknowledge time the bench requires that ev_valid is low and that the number and order of collected strobes already match its arithmetic model of the changed fields.

// File: rtl/intc_bank_pkg.sv
`timescale 1ns/1ps
package intc_bank_pkg;

  // How a decoded access merges into the stored register
  typedef enum logic [2:0] {
    ACC_NONE,   // no register hit
    ACC_OR,     // set address of a dual register
    ACC_ANDN,   // clear address of a dual register
    ACC_EN,     // single address, direct write, non-zero field enables
    ACC_MSK     // single clear address, direct write, 1 bit masks
  } acc_mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CALC,
    S_EMIT,
    S_DONE
  } bank_state_e;

endpackage

// File: rtl/intc_bank_decode.sv
`timescale 1ns/1ps
module intc_bank_decode
  import intc_bank_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 5,
  parameter int IDX_W  = 3,
  parameter logic [NREG-1:0][ADDR_W-1:0] SET_ADDR = '0,
  parameter logic [NREG-1:0][ADDR_W-1:0] CLR_ADDR = '0,
  parameter logic [NREG-1:0]             IS_PRIO  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output acc_mode_e         mode
);

  localparam logic [ADDR_W-1:0] AMASK = {{(ADDR_W-29){1'b0}}, {29{1'b1}}};

  logic [NREG-1:0] hit_v;
  acc_mode_e       mode_v [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam bit HAS_SET = (SET_ADDR[g] != '0);
    localparam bit HAS_CLR = (CLR_ADDR[g] != '0);
    logic set_hit, clr_hit;

    assign set_hit  = HAS_SET && ((addr & AMASK) == (SET_ADDR[g] & AMASK));
    assign clr_hit  = HAS_CLR && ((addr & AMASK) == (CLR_ADDR[g] & AMASK));
    assign hit_v[g] = set_hit | clr_hit;

    if (HAS_SET && HAS_CLR) begin : g_dual
      assign mode_v[g] = set_hit ? ACC_OR : ACC_ANDN;
    end else if (HAS_SET || IS_PRIO[g]) begin : g_en
      assign mode_v[g] = ACC_EN;
    end else begin : g_msk
      assign mode_v[g] = ACC_MSK;
    end
  end

  // lowest register index wins if two windows overlap
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    mode = ACC_NONE;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        mode = mode_v[i];
      end
    end
  end

endmodule

// File: rtl/intc_bank_fields.sv
`timescale 1ns/1ps
module intc_bank_fields #(
  parameter int DATA_W = 8,
  parameter int FW     = 1
) (
  input  logic [DATA_W-1:0] old_v,
  input  logic [DATA_W-1:0] new_v,
  input  logic              invert,
  output logic [DATA_W-1:0] diff,
  output logic [DATA_W-1:0] en
);

  localparam int NF = DATA_W / FW;

  // bit j of diff/en refers to the slice at bit offset j*FW
  for (genvar j = 0; j < DATA_W; j++) begin : g_fld
    if (j < NF) begin : g_live
      assign diff[j] = old_v[j*FW +: FW] != new_v[j*FW +: FW];
      assign en[j]   = (|new_v[j*FW +: FW]) ^ invert;
    end else begin : g_pad
      assign diff[j] = 1'b0;
      assign en[j]   = 1'b0;
    end
  end

endmodule

// File: rtl/intc_bank_msb.sv
`timescale 1ns/1ps
module intc_bank_msb #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] pos
);

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        pos   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank
  import intc_bank_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 8,
  parameter int NREG    = 5,
  parameter int SRC_W   = 8,
  parameter int PRIO_FW = 4,
  parameter logic [NREG-1:0][ADDR_W-1:0] SET_ADDR =
    {32'h0000_0118, 32'h0000_0110, 32'h0000_010C, 32'h0000_0000, 32'h0000_0100},
  parameter logic [NREG-1:0][ADDR_W-1:0] CLR_ADDR =
    {32'h0000_0000, 32'h0000_0114, 32'h0000_0000, 32'h0000_0108, 32'h0000_0104},
  parameter logic [NREG-1:0]             IS_PRIO  = 5'b11000,
  parameter logic [NREG-1:0][SRC_W-1:0]  SRC_BASE = {8'd28, 8'd24, 8'd16, 8'd8, 8'd0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic              ev_enable,
  output logic [SRC_W-1:0]  ev_src
);

  localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int FI_W    = $clog2(DATA_W);
  localparam int NF_PRIO = DATA_W / PRIO_FW;

  bank_state_e       state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic [DATA_W-1:0] regs [NREG];

  logic [DATA_W-1:0] pend_q, en_q;
  logic [SRC_W-1:0]  base_q;
  logic [FI_W:0]     nf_q;

  // ---------------- decode of the latched request ----------------
  logic             hit;
  logic [IDX_W-1:0] idx;
  acc_mode_e        mode;

  intc_bank_decode #(
    .ADDR_W(ADDR_W), .NREG(NREG), .IDX_W(IDX_W),
    .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR), .IS_PRIO(IS_PRIO)
  ) u_dec (
    .addr(addr_q), .hit(hit), .idx(idx), .mode(mode)
  );

  // ---------------- merge ----------------
  logic [DATA_W-1:0] old_v, new_v;
  logic              prio_sel;

  assign old_v    = hit ? regs[idx] : '0;
  assign prio_sel = hit & IS_PRIO[idx];

  always_comb begin
    unique case (mode)
      ACC_OR:         new_v = old_v | wdata_q;
      ACC_ANDN:       new_v = old_v & ~wdata_q;
      ACC_EN, ACC_MSK: new_v = wdata_q;
      default:        new_v = old_v;
    endcase
  end

  // ---------------- per-field change detection ----------------
  logic [DATA_W-1:0] diff_m, en_m, diff_p, en_p, diff_c, en_c;

  intc_bank_fields #(.DATA_W(DATA_W), .FW(1)) u_fmask (
    .old_v(old_v), .new_v(new_v), .invert(mode == ACC_MSK),
    .diff(diff_m), .en(en_m)
  );

  intc_bank_fields #(.DATA_W(DATA_W), .FW(PRIO_FW)) u_fprio (
    .old_v(old_v), .new_v(new_v), .invert(1'b0),
    .diff(diff_p), .en(en_p)
  );

  assign diff_c = (we_q && hit) ? (prio_sel ? diff_p : diff_m) : '0;
  assign en_c   = prio_sel ? en_p : en_m;

  logic [FI_W:0] nf_c;
  assign nf_c = prio_sel ? (FI_W+1)'(NF_PRIO) : (FI_W+1)'(DATA_W);

  // ---------------- strobe ordering ----------------
  logic            new_found, pend_found;
  logic [FI_W-1:0] new_pos, pend_pos;

  intc_bank_msb #(.W(DATA_W), .IW(FI_W)) u_msb_new (
    .vec(diff_c), .found(new_found), .pos(new_pos)
  );

  intc_bank_msb #(.W(DATA_W), .IW(FI_W)) u_msb_pend (
    .vec(pend_q), .found(pend_found), .pos(pend_pos)
  );

  // slice at offset p (from LSB) is field nf-1-p counted from the MSB end
  function automatic logic [SRC_W-1:0] src_of(input logic [SRC_W-1:0] base,
                                              input logic [FI_W:0]    nf,
                                              input logic [FI_W-1:0]  p);
    return base + SRC_W'(nf - (FI_W+1)'(p) - (FI_W+1)'(1));
  endfunction

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      pend_q    <= '0;
      en_q      <= '0;
      base_q    <= '0;
      nf_q      <= '0;
      bus_ready <= 1'b0;
      bus_rdata <= '0;
      ev_valid  <= 1'b0;
      ev_enable <= 1'b0;
      ev_src    <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (bus_valid) begin
            addr_q  <= bus_addr;
            wdata_q <= bus_wdata;
            we_q    <= bus_we;
            state   <= S_CALC;
          end
        end
        S_CALC: begin
          bus_rdata <= we_q ? '0 : old_v;
          if (we_q && hit) regs[idx] <= new_v;
          en_q   <= en_c;
          base_q <= SRC_BASE[idx];
          nf_q   <= nf_c;
          if (new_found) begin
            pend_q    <= diff_c & ~(DATA_W'(1) << new_pos);
            ev_valid  <= 1'b1;
            ev_enable <= en_c[new_pos];
            ev_src    <= src_of(SRC_BASE[idx], nf_c, new_pos);
            state     <= S_EMIT;
          end else begin
            pend_q    <= '0;
            bus_ready <= 1'b1;
            state     <= S_DONE;
          end
        end
        S_EMIT: begin
          if (ev_ready) begin
            if (pend_found) begin
              pend_q    <= pend_q & ~(DATA_W'(1) << pend_pos);
              ev_enable <= en_q[pend_pos];
              ev_src    <= src_of(base_q, nf_q, pend_pos);
            end else begin
              ev_valid  <= 1'b0;
              bus_ready <= 1'b1;
              state     <= S_DONE;
            end
          end
        end
        default: begin
          bus_ready <= 1'b0;
          state     <= S_IDLE;
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_EV_HOLD: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_src) && $stable(ev_enable)); // R8

  AST_NO_ACK_WITH_EV: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> !ev_valid); // R9

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready); // R9

  AST_READ_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == S_CALC) && !we_q |=> !ev_valid); // R10

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == S_CALC) && !hit |=> !ev_valid); // R11

endmodule

// File: tb/intc_bank_tb.sv
`timescale 1ns/1ps
module intc_bank_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_we;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_ready;
  logic [7:0]  bus_rdata;
  logic        ev_valid, ev_ready, ev_enable;
  logic [7:0]  ev_src;

  always #5 clk = ~clk;

  intc_bank #(
    .ADDR_W(32), .DATA_W(8), .NREG(5), .SRC_W(8), .PRIO_FW(4),
    .SET_ADDR({32'h118, 32'h110, 32'h10C, 32'h0, 32'h100}),
    .CLR_ADDR({32'h0, 32'h114, 32'h0, 32'h108, 32'h104}),
    .IS_PRIO(5'b11000),
    .SRC_BASE({8'd28, 8'd24, 8'd16, 8'd8, 8'd0})
  ) u_dut (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_enable(ev_enable),
    .ev_src(ev_src)
  );

  int checks = 0;
  int errors = 0;
  int n_ev   = 0;
  logic [7:0] got_s [16];
  logic       got_e [16];
  logic [7:0] model [5];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // throttled aggregator
  int rdy_seq = 0;
  initial begin
    ev_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      rdy_seq++;
      ev_ready = ((rdy_seq * 7) % 5) != 1 && (rdy_seq % 11) != 3;
    end
  end

  // strobe collector: a handshake visible at the negedge completes at the next posedge
  always @(negedge clk) begin
    if (!rst && ev_valid && ev_ready) begin
      if (n_ev < 16) begin
        got_s[n_ev] = ev_src;
        got_e[n_ev] = ev_enable;
      end
      n_ev++;
    end
  end

  function automatic logic [31:0] reg_addr(input int r, input bit clr);
    case (r)
      0:       return clr ? 32'h104 : 32'h100;
      1:       return 32'h108;
      2:       return 32'h10C;
      3:       return clr ? 32'h114 : 32'h110;
      default: return 32'h118;
    endcase
  endfunction

  task automatic xfer(input bit we, input logic [31:0] a, input logic [7:0] d,
                      output logic [7:0] rd);
    n_ev = 0;
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    do @(negedge clk); while (!bus_ready);
    rd = bus_rdata;
    chk(!ev_valid, "R9 strobe alongside ack", int'(ev_valid), 0);
    @(posedge clk); #1;
    bus_valid = 1'b0;
    @(negedge clk);
    chk(!bus_ready, "R9 ack longer than one cycle", int'(bus_ready), 0);
  endtask

  task automatic do_write(input int r, input bit clr, input logic [7:0] d,
                          input logic [2:0] al);
    logic [7:0] old_v, new_v, rd, exp_s [8];
    logic       exp_e [8];
    int         ne;
    string      tag;
    int         base [5] = '{0, 8, 16, 24, 28};
    old_v = model[r];
    ne    = 0;
    case (r)
      0: begin new_v = clr ? (old_v & ~d) : (old_v | d); tag = clr ? "R3" : "R2"; end
      1: begin new_v = d; tag = "R5"; end
      2: begin new_v = d; tag = "R4"; end
      3: begin new_v = clr ? (old_v & ~d) : (old_v | d); tag = "R7"; end
      default: begin new_v = d; tag = "R7"; end
    endcase
    if (r < 3) begin
      for (int k = 0; k < 8; k++) begin
        if (old_v[7-k] != new_v[7-k]) begin
          exp_s[ne] = 8'(base[r] + k);
          exp_e[ne] = (r == 1) ? !new_v[7-k] : new_v[7-k];
          ne++;
        end
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        logic [3:0] fo, fn;
        fo = 4'(old_v >> ((1 - k) * 4));
        fn = 4'(new_v >> ((1 - k) * 4));
        if (fo != fn) begin
          exp_s[ne] = 8'(base[r] + k);
          exp_e[ne] = (fn != 4'd0);
          ne++;
        end
      end
    end
    xfer(1'b1, reg_addr(r, clr) | {al, 29'b0}, d, rd);
    model[r] = new_v;
    chk(n_ev == ne, {tag, " R8 strobe count"}, n_ev, ne);
    for (int i = 0; i < ne && i < n_ev; i++) begin
      chk(got_s[i] == exp_s[i], {tag, " R6 R8 strobe source/order"}, got_s[i], exp_s[i]);
      chk(got_e[i] == exp_e[i], {tag, " strobe polarity"}, got_e[i], exp_e[i]);
    end
    xfer(1'b0, reg_addr(r, 1'b0), 8'h00, rd);
    chk(rd == new_v, {tag, " R10 readback"}, rd, new_v);
    chk(n_ev == 0, "R10 read strobed", n_ev, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst = 1'b1; bus_valid = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 5; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!bus_ready, "R12 bus_ready after reset", int'(bus_ready), 0);
    chk(!ev_valid, "R12 ev_valid after reset", int'(ev_valid), 0);
    for (int r = 0; r < 5; r++) begin
      xfer(1'b0, reg_addr(r, 1'b1), 8'h00, rd);
      chk(rd == 8'h00, "R12 register after reset", rd, 0);
    end

    // sweep every data value through every register kind
    for (int r = 0; r < 5; r++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] dv;
        bit         clr;
        dv  = 8'(d);
        clr = (r == 0 || r == 3) ? (dv[0] ^ dv[4]) : 1'b0;
        do_write(r, clr, dv, dv[3:1]);
      end
    end

    // aliases: upper three bits ignored
    xfer(1'b0, 32'hE000_0100, 8'h00, rd);
    chk(rd == model[0], "R1 alias read", rd, model[0]);
    xfer(1'b0, 32'h2000_0110, 8'h00, rd);
    chk(rd == model[3], "R1 alias read prio", rd, model[3]);
    // bit 28 still decoded
    xfer(1'b0, 32'h1000_0100, 8'h00, rd);
    chk(rd == 8'h00, "R1 R11 bit 28 must not alias", rd, 0);

    // unmatched writes: no strobe, no register change
    xfer(1'b1, 32'h1000_0104, 8'hFF, rd);
    chk(n_ev == 0, "R11 miss write strobed", n_ev, 0);
    xfer(1'b1, 32'h0000_0200, 8'hA5, rd);
    chk(n_ev == 0, "R11 miss write strobed", n_ev, 0);
    xfer(1'b0, 32'h0000_0200, 8'h00, rd);
    chk(rd == 8'h00, "R11 miss read", rd, 0);
    for (int r = 0; r < 5; r++) begin
      xfer(1'b0, reg_addr(r, 1'b0), 8'h00, rd);
      chk(rd == model[r], "R11 register disturbed by miss", rd, model[r]);
    end

    summary();
    $finish;
  end

endmodule